// File: doc/BRIEF.md
# Configuration Start-Up Sequencer

This block steps a programmable device from power-up to normal operation. After reset it passes through an initialization state, a memory-clear state of fixed length and a configure state. In the configure state it waits for a completion pulse from the configuration loader. When that pulse arrives, a short start-up phase begins. During start-up the sequencer enables the user I/O, releases the internal user-logic reset and asserts its own DONE indication. Each of these events falls on a fixed clock edge, and option inputs choose whether the reset release and the DONE assertion fall before or after the I/O enable.

Two status outputs mark the whole configuration period, one active high and one active low, so that external logic such as memory enables or bus drivers can be gated by them. DONE can be driven as an open-drain line that several devices share in a wired-AND. In that mode a device whose DONE is released still halts its start-up while any other device holds the shared line low. A restart input brings the sequencer back to initialization from any state.

Top module: `cfg_startup_seq`

## Requirements
- R1: While rst_n is low, io_en = 0, user_rst_n = 0, done_pull_low = 1, done_pullup_en = 0, cfg_act_hi = 1 and cfg_act_lo = 0.
- R2: cfg_act_hi = 1 and cfg_act_lo = 0 from reset through initialization, clear, configure and start-up. Both become inactive (cfg_act_hi = 0, cfg_act_lo = 1) on the fourth clock edge after the edge that samples load_done, unless start-up is frozen.
- R3: Let E0 be the clock edge that samples load_done = 1 in the configure state. io_en goes to 1 on edge E0+2.
- R4: With opt_rst_late = 0, user_rst_n goes to 1 on edge E0+1, one edge before io_en. With opt_rst_late = 1, it goes to 1 on edge E0+3, one edge after io_en.
- R5: With opt_done_late = 0, DONE asserts on edge E0+1. With opt_done_late = 1, it asserts on edge E0+3. DONE asserted is shown by done_pull_low = 0.
- R6: load_done is ignored in the initialization and clear states. A pulse there starts no start-up phase.
- R7: With opt_done_od = 1, while DONE is asserted and done_line_in reads 0 during start-up, all outputs hold their values. Start-up resumes on the first edge after done_line_in reads 1.
- R8: With opt_done_od = 0, done_pullup_en = 1 and done_line_in has no effect on start-up. With opt_done_od = 1, done_pullup_en = 0.
- R9: restart = 1 on a clock edge, in any state, returns the sequencer to initialization. On that same edge io_en, user_rst_n and DONE are deasserted and the status outputs become active.
- R10: After start-up the sequencer stays operational, with its outputs unchanged and load_done ignored, until restart or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous program/restart request |
| load_done | input | 1 | Completion pulse from the configuration loader |
| opt_rst_late | input | 1 | 1: release the user reset after the I/O enable; 0: before it |
| opt_done_late | input | 1 | 1: assert DONE after the I/O enable; 0: before it |
| opt_done_od | input | 1 | 1: open-drain DONE with line sensing; 0: pulled-up DONE |
| done_line_in | input | 1 | Sensed level of the shared DONE line |
| io_en | output | 1 | User I/O output enable |
| user_rst_n | output | 1 | Internal user-logic reset, low while held |
| done_pull_low | output | 1 | Drives the DONE pad low while this device is not done |
| done_pullup_en | output | 1 | Enables the DONE pad pull-up |
| cfg_act_hi | output | 1 | High during configuration and start-up |
| cfg_act_lo | output | 1 | Low during configuration and start-up |

## Verification
Start-up is run with all four combinations of the two timing options, and every output is checked on each edge from E0 to E0+4. This shows whether each event lands before or after the I/O enable, and whether any of them is off by one edge. One run with an open-drain DONE holds the peer line low for several cycles and then releases it, which shows that the freeze stops the whole sequence and that it resumes one edge after release. A run with a pulled-up DONE and the same low peer line shows that the line is ignored in that mode. Further runs pulse load_done during initialization and clear and during operation, and issue restart both in mid start-up and in operation, to separate ignored pulses from real state changes.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  typedef enum logic [2:0] {
    ST_INIT    = 3'd0,
    ST_CLEAR   = 3'd1,
    ST_CONFIG  = 3'd2,
    ST_STARTUP = 3'd3,
    ST_OPER    = 3'd4
  } cfg_state_e;

  localparam int STEP_W = 3;

  // Start-up step numbering: step 1 follows the load_done edge.
  localparam logic [STEP_W-1:0] STEP_FIRST = 3'd1;
  localparam logic [STEP_W-1:0] STEP_EARLY = 3'd2;
  localparam logic [STEP_W-1:0] STEP_IO    = 3'd3;
  localparam logic [STEP_W-1:0] STEP_LATE  = 3'd4;
  localparam logic [STEP_W-1:0] STEP_LAST  = STEP_LATE;

  localparam int N_EVENTS = 2;   // 0: user reset release, 1: DONE
  localparam int EV_RST   = 0;
  localparam int EV_DONE  = 1;

endpackage

// File: rtl/cfgseq_fsm.sv
module cfgseq_fsm
  import cfgseq_pkg::*;
#(
  parameter int CLEAR_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              load_done,
  input  logic              hold,
  output cfg_state_e        state_o,
  output logic [STEP_W-1:0] nxt_step_o,
  output logic              act_hi_o,
  output logic              act_lo_o
);

  localparam int CW = $clog2(CLEAR_CYCLES + 1);
  localparam logic [CW-1:0] CLR_LAST = CW'(CLEAR_CYCLES - 1);

  cfg_state_e        state_q, nxt_state;
  logic [STEP_W-1:0] step_q, nxt_step;
  logic [CW-1:0]     cnt_q, nxt_cnt;
  logic              step_en, cnt_en;

  always_comb begin
    nxt_state = state_q;
    nxt_step  = step_q;
    nxt_cnt   = cnt_q;
    if (restart) begin
      nxt_state = ST_INIT;
      nxt_step  = '0;
      nxt_cnt   = '0;
    end else begin
      unique case (state_q)
        ST_INIT: begin
          nxt_state = ST_CLEAR;
          nxt_cnt   = '0;
        end
        ST_CLEAR: begin
          if (cnt_q == CLR_LAST) nxt_state = ST_CONFIG;
          else                   nxt_cnt   = cnt_q + 1'b1;
        end
        ST_CONFIG: begin
          if (load_done) begin
            nxt_state = ST_STARTUP;
            nxt_step  = STEP_FIRST;
          end
        end
        ST_STARTUP: begin
          if (!hold) begin
            if (step_q == STEP_LAST) nxt_state = ST_OPER;
            else                     nxt_step  = step_q + 1'b1;
          end
        end
        ST_OPER: ;
        default: nxt_state = ST_INIT;
      endcase
    end
  end

  assign step_en = (nxt_step != step_q);
  assign cnt_en  = (nxt_cnt != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_INIT;
      step_q   <= '0;
      cnt_q    <= '0;
      act_hi_o <= 1'b1;
      act_lo_o <= 1'b0;
    end else begin
      state_q <= nxt_state;
      if (step_en) step_q <= nxt_step;
      if (cnt_en)  cnt_q  <= nxt_cnt;
      act_hi_o <= (nxt_state != ST_OPER);
      act_lo_o <= (nxt_state == ST_OPER);
    end
  end

  assign state_o    = state_q;
  assign nxt_step_o = nxt_step;

  p_restart_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (state_q == ST_INIT));

  p_load_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INIT || state_q == ST_CLEAR) |=> (state_q != ST_STARTUP));

  p_oper_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OPER && !restart) |=> (state_q == ST_OPER));

endmodule

// File: rtl/cfgseq_release.sv
module cfgseq_release
  import cfgseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] nxt_step,
  input  logic              opt_rst_late,
  input  logic              opt_done_late,
  output logic              io_en,
  output logic              rst_rel,
  output logic              done_q
);

  logic [N_EVENTS-1:0] late_sel;
  logic [N_EVENTS-1:0] ev_q;

  assign late_sel[EV_RST]  = opt_rst_late;
  assign late_sel[EV_DONE] = opt_done_late;

  for (genvar g = 0; g < N_EVENTS; g++) begin : g_event
    logic [STEP_W-1:0] thr;
    assign thr = late_sel[g] ? STEP_LATE : STEP_EARLY;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ev_q[g] <= 1'b0;
      else        ev_q[g] <= (nxt_step >= thr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) io_en <= 1'b0;
    else        io_en <= (nxt_step >= STEP_IO);
  end

  assign rst_rel = ev_q[EV_RST];
  assign done_q  = ev_q[EV_DONE];

  p_rel_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_rel) |-> (io_en == opt_rst_late));

  p_done_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (io_en == opt_done_late));

endmodule

// File: rtl/cfgseq_done.sv
module cfgseq_done (
  input  logic clk,
  input  logic rst_n,
  input  logic opt_done_od,
  input  logic done_q,
  input  logic done_line_in,
  input  logic in_startup,
  output logic pull_low,
  output logic pullup_en,
  output logic hold
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pullup_en <= 1'b0;
    else        pullup_en <= ~opt_done_od;
  end

  assign pull_low = ~done_q;
  assign hold     = opt_done_od & done_q & ~done_line_in & in_startup;

endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
  import cfgseq_pkg::*;
#(
  parameter int CLEAR_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic load_done,
  input  logic opt_rst_late,
  input  logic opt_done_late,
  input  logic opt_done_od,
  input  logic done_line_in,
  output logic io_en,
  output logic user_rst_n,
  output logic done_pull_low,
  output logic done_pullup_en,
  output logic cfg_act_hi,
  output logic cfg_act_lo
);

  cfg_state_e        state;
  logic [STEP_W-1:0] nxt_step;
  logic              hold, done_q, in_startup;

  assign in_startup = (state == ST_STARTUP);

  cfgseq_fsm #(.CLEAR_CYCLES(CLEAR_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .restart(restart), .load_done(load_done),
    .hold(hold), .state_o(state), .nxt_step_o(nxt_step),
    .act_hi_o(cfg_act_hi), .act_lo_o(cfg_act_lo)
  );

  cfgseq_release u_rel (
    .clk(clk), .rst_n(rst_n), .nxt_step(nxt_step),
    .opt_rst_late(opt_rst_late), .opt_done_late(opt_done_late),
    .io_en(io_en), .rst_rel(user_rst_n), .done_q(done_q)
  );

  cfgseq_done u_done (
    .clk(clk), .rst_n(rst_n), .opt_done_od(opt_done_od), .done_q(done_q),
    .done_line_in(done_line_in), .in_startup(in_startup),
    .pull_low(done_pull_low), .pullup_en(done_pullup_en), .hold(hold)
  );

  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !restart) |=> ($stable(io_en) && $stable(user_rst_n) && $stable(cfg_act_hi)));

endmodule

// File: tb/cfg_startup_seq_tb.sv
module cfg_startup_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CLR = 8;

  logic clk = 1'b0;
  logic rst_n, restart, load_done, opt_rst_late, opt_done_late, opt_done_od;
  logic peer_ok;
  logic done_line_in;
  logic io_en, user_rst_n, done_pull_low, done_pullup_en, cfg_act_hi, cfg_act_lo;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Wired-AND model of the shared DONE line.
  assign done_line_in = ~done_pull_low & peer_ok;

  cfg_startup_seq #(.CLEAR_CYCLES(CLR)) dut_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .load_done(load_done),
    .opt_rst_late(opt_rst_late), .opt_done_late(opt_done_late),
    .opt_done_od(opt_done_od), .done_line_in(done_line_in),
    .io_en(io_en), .user_rst_n(user_rst_n), .done_pull_low(done_pull_low),
    .done_pullup_en(done_pullup_en), .cfg_act_hi(cfg_act_hi), .cfg_act_lo(cfg_act_lo)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req, logic e_io, logic e_rel, logic e_done, logic e_act);
    chk(req, "io_en", io_en, e_io);
    chk(req, "user_rst_n", user_rst_n, e_rel);
    chk(req, "done_pull_low", done_pull_low, ~e_done);
    chk(req, "cfg_act_hi", cfg_act_hi, e_act);
    chk(req, "cfg_act_lo", cfg_act_lo, ~e_act);
  endtask

  task automatic reach_config();
    restart = 1'b1; tick(); restart = 1'b0;
    repeat (CLR + 4) tick();
  endtask

  // R3 R4 R5 R2 R8: timeline of one start-up
  task automatic t_startup(logic rl, logic dl, logic od, logic peer);
    opt_rst_late = rl; opt_done_late = dl; opt_done_od = od; peer_ok = peer;
    reach_config();
    chk("R2", "busy before start", cfg_act_hi, 1'b1);
    chk("R8", "pullup_en", done_pullup_en, ~od);
    load_done = 1'b1; tick(); load_done = 1'b0;   // E0
    chk_all("R3", 1'b0, 1'b0, 1'b0, 1'b1);
    for (int k = 1; k <= 4; k++) begin
      tick();
      chk("R3", $sformatf("io_en k=%0d", k), io_en, k >= 2);
      chk("R4", $sformatf("user_rst_n k=%0d rl=%0b", k, rl), user_rst_n, k >= (rl ? 3 : 1));
      chk("R5", $sformatf("done k=%0d dl=%0b", k, dl), ~done_pull_low, k >= (dl ? 3 : 1));
      chk("R2", $sformatf("act_hi k=%0d", k), cfg_act_hi, k < 4);
      chk("R2", $sformatf("act_lo k=%0d", k), cfg_act_lo, k >= 4);
    end
  endtask

  // R6: load_done during init and clear is ignored
  task automatic t_ignore();
    opt_done_od = 1'b0; peer_ok = 1'b1;
    restart = 1'b1; tick(); restart = 1'b0;
    load_done = 1'b1; tick(); load_done = 1'b0;   // sampled in init
    tick();
    load_done = 1'b1; tick(); load_done = 1'b0;   // sampled in clear
    for (int i = 0; i < 8; i++) begin
      tick();
      chk("R6", "io_en stays off", io_en, 1'b0);
      chk("R6", "still configuring", cfg_act_hi, 1'b1);
    end
  endtask

  // R7: open-drain freeze while a peer holds DONE low
  task automatic t_freeze();
    opt_rst_late = 1'b1; opt_done_late = 1'b0; opt_done_od = 1'b1; peer_ok = 1'b0;
    reach_config();
    chk("R8", "pullup off in od", done_pullup_en, 1'b0);
    load_done = 1'b1; tick(); load_done = 1'b0;
    tick();
    chk("R7", "done released", done_pull_low, 1'b0);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk_all("R7", 1'b0, 1'b0, 1'b1, 1'b1);
    end
    peer_ok = 1'b1;
    tick(); chk_all("R7", 1'b1, 1'b0, 1'b1, 1'b1);
    tick(); chk_all("R7", 1'b1, 1'b1, 1'b1, 1'b1);
    tick(); chk_all("R7", 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  // R10 then R9: stay operational, then restart
  task automatic t_oper_restart();
    for (int i = 0; i < 12; i++) begin
      load_done = i[0];
      tick();
      chk_all("R10", 1'b1, 1'b1, 1'b1, 1'b0);
    end
    load_done = 1'b0;
    restart = 1'b1; tick(); restart = 1'b0;
    chk_all("R9", 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  // R9: restart in mid start-up
  task automatic t_restart_mid();
    opt_rst_late = 1'b0; opt_done_late = 1'b0; opt_done_od = 1'b0; peer_ok = 1'b1;
    reach_config();
    load_done = 1'b1; tick(); load_done = 1'b0;
    tick(); tick();
    chk("R9", "io_en on before restart", io_en, 1'b1);
    restart = 1'b1; tick(); restart = 1'b0;
    chk_all("R9", 1'b0, 1'b0, 1'b0, 1'b1);
    repeat (4) tick();
    chk("R9", "no resume after restart", io_en, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; restart = 1'b0; load_done = 1'b0;
    opt_rst_late = 1'b0; opt_done_late = 1'b0; opt_done_od = 1'b0; peer_ok = 1'b1;
    repeat (3) tick();
    chk_all("R1", 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R1", "pullup_en", done_pullup_en, 1'b0);
    rst_n = 1'b1;
    tick();
    t_startup(1'b0, 1'b0, 1'b0, 1'b1);
    t_oper_restart();
    t_startup(1'b1, 1'b0, 1'b0, 1'b1);
    t_startup(1'b0, 1'b1, 1'b1, 1'b1);
    t_startup(1'b1, 1'b1, 1'b0, 1'b1);
    t_startup(1'b0, 1'b0, 1'b0, 1'b0);   // R8: pulled-up, low line ignored
    t_ignore();
    t_freeze();
    t_restart_mid();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule